// File: doc/BRIEF.md
# Instruction Prefix Register Unit

This unit holds the two 32-bit prefix registers that let a fixed-length 32-bit instruction carry extra encoding bits. One register is the supplement register, which holds one 30-bit prefix or two 15-bit prefixes. The other is the augment register, which holds four 6-bit items, a selection counter and mode flags. Prefix-load instructions with a 24-bit immediate write these registers. An instruction decoded with its extend bit set then draws a prefix of 0, 6, 12, 15, 24 or 30 bits from them and advances the shared state. The unit returns the prefix right-aligned, together with its length in bits, one cycle later.

The decode stage presents one operation per cycle in program order. A control-transfer strobe clears both registers, unless the transfer is marked as a program-relative conditional jump, which keeps them. At the first cycle of each instruction block the unit copies both registers into shadow registers. A restore strobe reloads the live registers from these copies, so that an interrupted block can be restarted with the prefix state it had on entry. What a prefix means to the instruction that receives it is decided downstream and is not part of this unit.

Software must place a prefix load in an earlier block than the extend instructions that use it. The unit applies operations strictly in the order they arrive. Within a block, extend instructions therefore consume prefix state in slot order.

Top module: `pfx_unit`

## Requirements
- R1: A synchronous active-high reset sets the supplement register, the augment register, both shadow copies, `pfx_valid_o`, `pfx_len_o` and `pfx_bits_o` to zero.
- R2: An extend operation (`op_i`=1) made while the augment Active bit (bit 30) is 0 yields a result with length 0 and bits 0, and leaves both registers unchanged.
- R3: When Active=1 and Direct (augment bit 31) is 1, an extend operation yields the 6-bit item selected by the counter (augment bits 28:27). Counter value c selects the item at bits [23-6c:18-6c], so item 0 is at 23:18. The counter then advances by one unless it is already 3.
- R4: When Active=1, Direct=0 and supplement bit 31 (pair mode) is 1, an extend operation uses field A (supplement bits 29:15) if supplement bit 30 (second flag) is 0, and field B (bits 14:0) otherwise. It yields all 15 bits if the matching augment flag is 1 (bit 26 for A, bit 25 for B), and the low 12 bits otherwise. The second flag is then set to 1.
- R5: When Active=1, Direct=0 and pair mode is 0, an extend operation yields supplement bits 29:0 (30 bits) if augment bit 26 is 1, and supplement bits 23:0 (24 bits) otherwise.
- R6: Wide loads write supplement bits 23:0 with the immediate and clear bits 31:30. The clearing form (`op_i`=2) zeroes bits 29:24 and augment bit 26. The augmenting form (`op_i`=3) fills bits 29:24 with the counter-selected item, advances the counter as in R3, and sets augment bit 26. Both forms set Active.
- R7: Pair loads set pair mode, clear the second flag, and write immediate bits 23:12 to field A bits 11:0 and immediate bits 11:0 to field B bits 11:0. The clearing form (`op_i`=4) zeroes both fields' top 3 bits and augment bits 26:25. The augmenting form (`op_i`=5) puts item bits 5:3 in A's top 3 bits and item bits 2:0 in B's top 3 bits, advances the counter, and sets augment bits 26:25. Both forms set Active.
- R8: Augment loads write augment bits 23:0 with the immediate, set Active, zero the counter, and keep bits 26:25. `op_i`=6 sets Direct and `op_i`=7 clears it.
- R9: A transfer (`xfer_i`) with `xfer_keep_i`=0 clears both registers; with `xfer_keep_i`=1 it leaves them unchanged. In either case, any operation presented in the same cycle is ignored.
- R10: When `blk_start_i` is 1, the shadow copies take the register values held before that cycle's operation. When `restore_i` is 1, the registers are reloaded from the shadow copies and all other inputs are ignored.
- R11: An extend result appears on the cycle after the extend operation, with `pfx_valid_o` high for exactly that cycle. The prefix is right-aligned in `pfx_bits_o`, and all bits at or above `pfx_len_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start_i | input | 1 | First cycle of an instruction block; captures shadow copies |
| op_i | input | 3 | 0 none, 1 extend, 2/3 wide load clear/augment, 4/5 pair load clear/augment, 6/7 augment load with Direct set/clear |
| imm_i | input | 24 | Immediate of a prefix-load operation |
| xfer_i | input | 1 | Control transfer taken |
| xfer_keep_i | input | 1 | Transfer is a program-relative conditional jump |
| restore_i | input | 1 | Reload registers from the shadow copies |
| pfx_valid_o | output | 1 | Extend result valid |
| pfx_len_o | output | 5 | Prefix length in bits |
| pfx_bits_o | output | 30 | Prefix, right-aligned |
| sup_o | output | 32 | Supplement register |
| aug_o | output | 32 | Augment register |

## Verification
The functions that can coincide are shadow capture at block entry and a register update in the same cycle. The bench drives `blk_start_i` together with a clearing wide load: `sup_o` must show the new load, and a restore issued next must bring back the values from before the load, not after it. A second coincidence is a transfer that keeps the registers, arriving with an extend operation. It is judged by unchanged register outputs and by the absence of any result the scoreboard did not expect.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int REG_W   = 32;
  localparam int IMM_W   = 24;
  localparam int ITEM_W  = 6;
  localparam int N_ITEMS = 4;
  localparam int FIELD_W = 15;
  localparam int HALF_W  = ITEM_W / 2;
  localparam int SHORT_W = FIELD_W - HALF_W;
  localparam int PFX_W   = 2 * FIELD_W;
  localparam int LEN_W   = $clog2(PFX_W + 1);
  localparam int CNT_W   = $clog2(N_ITEMS);

  // augment register bit positions
  localparam int DIR_B  = REG_W - 1;
  localparam int ACT_B  = REG_W - 2;
  localparam int CNT_LO = REG_W - 3 - CNT_W;
  localparam int FA_B   = CNT_LO - 1;
  localparam int FB_B   = CNT_LO - 2;
  // supplement register bit positions
  localparam int PAIR_B = REG_W - 1;
  localparam int SEC_B  = REG_W - 2;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_EXT      = 3'd1,
    OP_WIDE_CLR = 3'd2,
    OP_WIDE_AUG = 3'd3,
    OP_PAIR_CLR = 3'd4,
    OP_PAIR_AUG = 3'd5,
    OP_AUG_DIR  = 3'd6,
    OP_AUG_IND  = 3'd7
  } pfx_op_e;

  function automatic logic [ITEM_W-1:0] item_at(input logic [REG_W-1:0] a);
    logic [CNT_W-1:0] c;
    c = a[CNT_LO +: CNT_W];
    return a[(N_ITEMS - 1 - int'(c)) * ITEM_W +: ITEM_W];
  endfunction

  function automatic logic [REG_W-1:0] cnt_adv(input logic [REG_W-1:0] a);
    logic [REG_W-1:0] r;
    r = a;
    if (a[CNT_LO +: CNT_W] != CNT_W'(N_ITEMS - 1))
      r[CNT_LO +: CNT_W] = a[CNT_LO +: CNT_W] + 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/pfx_extract.sv
module pfx_extract
  import pfx_pkg::*;
(
  input  logic [REG_W-1:0] sup_i,
  input  logic [REG_W-1:0] aug_i,
  output logic [PFX_W-1:0] bits_o,
  output logic [LEN_W-1:0] len_o,
  output logic [REG_W-1:0] sup_nx_o,
  output logic [REG_W-1:0] aug_nx_o
);
  logic [FIELD_W-1:0] field;
  logic               full;

  always_comb begin
    sup_nx_o = sup_i;
    aug_nx_o = aug_i;
    bits_o   = '0;
    len_o    = '0;
    field    = sup_i[SEC_B] ? sup_i[FIELD_W-1:0] : sup_i[PFX_W-1:FIELD_W];
    full     = sup_i[SEC_B] ? aug_i[FB_B] : aug_i[FA_B];
    if (aug_i[ACT_B]) begin
      if (aug_i[DIR_B]) begin
        bits_o   = PFX_W'(item_at(aug_i));
        len_o    = LEN_W'(ITEM_W);
        aug_nx_o = cnt_adv(aug_i);
      end else if (sup_i[PAIR_B]) begin
        if (full) begin
          bits_o = PFX_W'(field);
          len_o  = LEN_W'(FIELD_W);
        end else begin
          bits_o = PFX_W'(field[SHORT_W-1:0]);
          len_o  = LEN_W'(SHORT_W);
        end
        sup_nx_o[SEC_B] = 1'b1;
      end else if (aug_i[FA_B]) begin
        bits_o = sup_i[PFX_W-1:0];
        len_o  = LEN_W'(PFX_W);
      end else begin
        bits_o = PFX_W'(sup_i[IMM_W-1:0]);
        len_o  = LEN_W'(IMM_W);
      end
    end
  end
endmodule

// File: rtl/pfx_load.sv
module pfx_load
  import pfx_pkg::*;
(
  input  logic [2:0]       op_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [REG_W-1:0] sup_i,
  input  logic [REG_W-1:0] aug_i,
  output logic             hit_o,
  output logic [REG_W-1:0] sup_nx_o,
  output logic [REG_W-1:0] aug_nx_o
);
  logic [ITEM_W-1:0] item;
  pfx_op_e           op;

  assign op   = pfx_op_e'(op_i);
  assign item = item_at(aug_i);

  always_comb begin
    sup_nx_o = sup_i;
    aug_nx_o = aug_i;
    hit_o    = 1'b1;
    unique case (op)
      OP_WIDE_CLR, OP_WIDE_AUG: begin
        sup_nx_o = '0;
        sup_nx_o[IMM_W-1:0] = imm_i;
        if (op == OP_WIDE_AUG) begin
          sup_nx_o[PFX_W-1 -: ITEM_W] = item;
          aug_nx_o = cnt_adv(aug_i);
        end
        aug_nx_o[FA_B]  = (op == OP_WIDE_AUG);
        aug_nx_o[ACT_B] = 1'b1;
      end
      OP_PAIR_CLR, OP_PAIR_AUG: begin
        sup_nx_o = '0;
        sup_nx_o[PAIR_B] = 1'b1;
        sup_nx_o[FIELD_W +: SHORT_W] = imm_i[IMM_W-1 -: SHORT_W];
        sup_nx_o[0 +: SHORT_W]       = imm_i[SHORT_W-1:0];
        if (op == OP_PAIR_AUG) begin
          sup_nx_o[PFX_W-1 -: HALF_W]   = item[ITEM_W-1 -: HALF_W];
          sup_nx_o[FIELD_W-1 -: HALF_W] = item[HALF_W-1:0];
          aug_nx_o = cnt_adv(aug_i);
        end
        aug_nx_o[FA_B]  = (op == OP_PAIR_AUG);
        aug_nx_o[FB_B]  = (op == OP_PAIR_AUG);
        aug_nx_o[ACT_B] = 1'b1;
      end
      OP_AUG_DIR, OP_AUG_IND: begin
        aug_nx_o[IMM_W-1:0]           = imm_i;
        aug_nx_o[CNT_LO +: CNT_W]     = '0;
        aug_nx_o[ACT_B]               = 1'b1;
        aug_nx_o[DIR_B]               = (op == OP_AUG_DIR);
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pfx_unit.sv
module pfx_unit
  import pfx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_start_i,
  input  logic [2:0]       op_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             xfer_i,
  input  logic             xfer_keep_i,
  input  logic             restore_i,
  output logic             pfx_valid_o,
  output logic [LEN_W-1:0] pfx_len_o,
  output logic [PFX_W-1:0] pfx_bits_o,
  output logic [REG_W-1:0] sup_o,
  output logic [REG_W-1:0] aug_o
);
  logic [REG_W-1:0] sup_q, aug_q, sh_sup_q, sh_aug_q;
  logic [REG_W-1:0] ext_sup, ext_aug, ld_sup, ld_aug;
  logic [PFX_W-1:0] ext_bits;
  logic [LEN_W-1:0] ext_len;
  logic             ld_hit;

  pfx_extract u_ext (
    .sup_i(sup_q), .aug_i(aug_q),
    .bits_o(ext_bits), .len_o(ext_len),
    .sup_nx_o(ext_sup), .aug_nx_o(ext_aug)
  );

  pfx_load u_ld (
    .op_i(op_i), .imm_i(imm_i), .sup_i(sup_q), .aug_i(aug_q),
    .hit_o(ld_hit), .sup_nx_o(ld_sup), .aug_nx_o(ld_aug)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_q       <= '0;
      aug_q       <= '0;
      sh_sup_q    <= '0;
      sh_aug_q    <= '0;
      pfx_valid_o <= 1'b0;
      pfx_len_o   <= '0;
      pfx_bits_o  <= '0;
    end else begin
      pfx_valid_o <= 1'b0;
      if (restore_i) begin
        sup_q <= sh_sup_q;
        aug_q <= sh_aug_q;
      end else begin
        if (blk_start_i) begin
          sh_sup_q <= sup_q;
          sh_aug_q <= aug_q;
        end
        if (xfer_i) begin
          if (!xfer_keep_i) begin
            sup_q <= '0;
            aug_q <= '0;
          end
        end else if (op_i == OP_EXT) begin
          sup_q       <= ext_sup;
          aug_q       <= ext_aug;
          pfx_valid_o <= 1'b1;
          pfx_len_o   <= ext_len;
          pfx_bits_o  <= ext_bits;
        end else if (ld_hit) begin
          sup_q <= ld_sup;
          aug_q <= ld_aug;
        end
      end
    end
  end

  assign sup_o = sup_q;
  assign aug_o = aug_q;
endmodule

// File: rtl/pfx_unit_chk.sv
module pfx_unit_chk
  import pfx_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op_i,
  input logic             xfer_i,
  input logic             xfer_keep_i,
  input logic             restore_i,
  input logic             pfx_valid_o,
  input logic [LEN_W-1:0] pfx_len_o,
  input logic [PFX_W-1:0] pfx_bits_o,
  input logic [REG_W-1:0] sup_q,
  input logic [REG_W-1:0] aug_q,
  input logic [REG_W-1:0] sh_sup_q,
  input logic [REG_W-1:0] sh_aug_q
);
  logic plain;
  assign plain = !xfer_i && !restore_i && (op_i == OP_EXT);

  assert_inactive_R2: assert property (@(posedge clk) disable iff (rst)
    (plain && !aug_q[ACT_B]) |=> (pfx_valid_o && pfx_len_o == '0));

  assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (rst)
    (plain && aug_q[ACT_B] && aug_q[DIR_B] && aug_q[CNT_LO +: CNT_W] == CNT_W'(N_ITEMS - 1))
    |=> (aug_q[CNT_LO +: CNT_W] == CNT_W'(N_ITEMS - 1)));

  assert_second_set_R4: assert property (@(posedge clk) disable iff (rst)
    (plain && aug_q[ACT_B] && !aug_q[DIR_B] && sup_q[PAIR_B]) |=> sup_q[SEC_B]);

  assert_xfer_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && !xfer_keep_i && !restore_i) |=> (sup_q == '0 && aug_q == '0));

  assert_xfer_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && xfer_keep_i && !restore_i) |=> ($stable(sup_q) && $stable(aug_q) && !pfx_valid_o));

  assert_restore_R10: assert property (@(posedge clk) disable iff (rst)
    restore_i |=> (sup_q == $past(sh_sup_q) && aug_q == $past(sh_aug_q)));

  assert_len_legal_R11: assert property (@(posedge clk) disable iff (rst)
    pfx_valid_o |-> (pfx_len_o inside {5'd0, 5'd6, 5'd12, 5'd15, 5'd24, 5'd30}));

  assert_bits_fit_R11: assert property (@(posedge clk) disable iff (rst)
    pfx_valid_o |-> ((pfx_bits_o >> pfx_len_o) == '0));

  assert_valid_cause_R11: assert property (@(posedge clk) disable iff (rst)
    plain |=> pfx_valid_o);
endmodule

bind pfx_unit pfx_unit_chk u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .xfer_i(xfer_i), .xfer_keep_i(xfer_keep_i),
  .restore_i(restore_i), .pfx_valid_o(pfx_valid_o), .pfx_len_o(pfx_len_o),
  .pfx_bits_o(pfx_bits_o), .sup_q(sup_q), .aug_q(aug_q),
  .sh_sup_q(sh_sup_q), .sh_aug_q(sh_aug_q)
);

// File: tb/pfx_unit_tb.sv
`timescale 1ns/1ps
module pfx_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        blk_start_i;
  logic [2:0]  op_i;
  logic [23:0] imm_i;
  logic        xfer_i, xfer_keep_i, restore_i;
  logic        pfx_valid_o;
  logic [4:0]  pfx_len_o;
  logic [29:0] pfx_bits_o;
  logic [31:0] sup_o, aug_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [34:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pfx_unit u_dut (
    .clk(clk), .rst(rst), .blk_start_i(blk_start_i), .op_i(op_i), .imm_i(imm_i),
    .xfer_i(xfer_i), .xfer_keep_i(xfer_keep_i), .restore_i(restore_i),
    .pfx_valid_o(pfx_valid_o), .pfx_len_o(pfx_len_o), .pfx_bits_o(pfx_bits_o),
    .sup_o(sup_o), .aug_o(aug_o)
  );

  task automatic chk(string tag, logic [34:0] act, logic [34:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one operation for one cycle, queue the expected prefix
  task automatic step(logic [2:0] op, logic [23:0] imm, string tag = "",
                      logic [4:0] elen = 0, logic [29:0] ebits = 0);
    op_i  = op;
    imm_i = imm;
    if (op == 3'd1 && !xfer_i && !restore_i) begin
      exp_q.push_back({elen, ebits});
      tag_q.push_back(tag);
    end
    @(negedge clk);
    op_i = 3'd0; blk_start_i = 1'b0; xfer_i = 1'b0; xfer_keep_i = 1'b0; restore_i = 1'b0;
  endtask

  // monitor: compare each produced prefix against the scoreboard
  always @(negedge clk) begin
    if (!rst && pfx_valid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11 unexpected result actual=%h expected=none", {pfx_len_o, pfx_bits_o});
      end else begin
        chk(tag_q.pop_front(), {pfx_len_o, pfx_bits_o}, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; blk_start_i = 0; op_i = 0; imm_i = 0;
    xfer_i = 0; xfer_keep_i = 0; restore_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset regs", {3'd0, sup_o}, 35'd0);
    chk("R1 reset aug",  {3'd0, aug_o}, 35'd0);
    chk("R1 reset out",  {4'd0, pfx_valid_o, pfx_len_o, pfx_bits_o}, 35'd0);

    step(3'd1, 0, "R2 inactive extend", 0, 0);
    chk("R2 regs untouched", {3'd0, aug_o}, 35'd0);

    // R8 augment load with Direct
    step(3'd6, 24'h462CC5);
    chk("R8 direct load", {3'd0, aug_o}, {3'd0, 32'hC0462CC5});
    // R3 direct items, counter saturates
    step(3'd1, 0, "R3 item0", 5'd6, 30'h11);
    step(3'd1, 0, "R3 item1", 5'd6, 30'h22);
    step(3'd1, 0, "R3 item2", 5'd6, 30'h33);
    step(3'd1, 0, "R3 item3", 5'd6, 30'h05);
    step(3'd1, 0, "R3 saturated", 5'd6, 30'h05);
    chk("R3 counter at 3", {3'd0, aug_o}, {3'd0, 32'hD8462CC5});

    step(3'd7, 24'h462CC5);
    chk("R8 indirect load", {3'd0, aug_o}, {3'd0, 32'h40462CC5});

    // R6 / R5 wide clearing load, 24-bit prefix
    step(3'd2, 24'hABCDEF);
    chk("R6 wide clear sup", {3'd0, sup_o}, {3'd0, 32'h00ABCDEF});
    step(3'd1, 0, "R5 24-bit", 5'd24, 30'h0ABCDEF);
    // wide augmenting load, 30-bit prefix
    step(3'd3, 24'h123456);
    chk("R6 wide aug sup", {3'd0, sup_o}, {3'd0, 32'h11123456});
    chk("R6 wide aug aug", {3'd0, aug_o}, {3'd0, 32'h4C462CC5});
    step(3'd1, 0, "R5 30-bit", 5'd30, 30'h11123456);

    // R7 / R4 pair clearing load, 12-bit prefixes
    step(3'd4, 24'hABC123);
    chk("R7 pair clear sup", {3'd0, sup_o}, {3'd0, 32'h855E0123});
    chk("R7 pair clear aug", {3'd0, aug_o}, {3'd0, 32'h48462CC5});
    step(3'd1, 0, "R4 first 12", 5'd12, 30'hABC);
    chk("R4 second flag set", {3'd0, sup_o}, {3'd0, 32'hC55E0123});
    step(3'd1, 0, "R4 second 12", 5'd12, 30'h123);
    step(3'd1, 0, "R4 second reused", 5'd12, 30'h123);

    // pair augmenting load, 15-bit prefixes
    step(3'd5, 24'h0F00F0);
    chk("R7 pair aug sup", {3'd0, sup_o}, {3'd0, 32'hA07820F0});
    chk("R7 pair aug aug", {3'd0, aug_o}, {3'd0, 32'h56462CC5});
    step(3'd1, 0, "R4 first 15", 5'd15, 30'h40F0);
    step(3'd1, 0, "R4 second 15", 5'd15, 30'h20F0);

    // R10 shadow capture coinciding with a load, then restore
    blk_start_i = 1'b1;
    step(3'd2, 24'h000001);
    chk("R10 load with block start sup", {3'd0, sup_o}, {3'd0, 32'h00000001});
    chk("R10 load with block start aug", {3'd0, aug_o}, {3'd0, 32'h52462CC5});
    restore_i = 1'b1;
    step(3'd1, 0);
    chk("R10 restore sup", {3'd0, sup_o}, {3'd0, 32'hE07820F0});
    chk("R10 restore aug", {3'd0, aug_o}, {3'd0, 32'h56462CC5});

    // R9 keeping transfer with a same-cycle extend
    xfer_i = 1'b1; xfer_keep_i = 1'b1;
    step(3'd1, 0);
    chk("R9 keep sup", {3'd0, sup_o}, {3'd0, 32'hE07820F0});
    chk("R9 keep aug", {3'd0, aug_o}, {3'd0, 32'h56462CC5});
    // clearing transfer
    xfer_i = 1'b1;
    step(3'd0, 0);
    chk("R9 clear sup", {3'd0, sup_o}, 35'd0);
    chk("R9 clear aug", {3'd0, aug_o}, 35'd0);
    step(3'd1, 0, "R2 after clear", 0, 0);

    step(3'd0, 0);
    step(3'd0, 0);
    chk("R11 scoreboard drained", 35'(exp_q.size()), 35'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule